// File: doc/BRIEF.md
# Host-to-Firmware Command Mailbox

This block is the meeting point between a host processor and an embedded power-management controller. The host posts a command through a small word-addressed register window. It can first fill a 16-byte outbound data area and two 32-bit pointer words. The firmware side sees a one-cycle doorbell pulse, the decoded command fields, the pointers and the outbound data. When it has done the work, the firmware loads its result words into a 16-byte inbound area and strobes `fw_done` with an error flag and an 8-bit error code.

The command word has four fields. The opcode sits in the low byte. Bit 8 asks for a completion interrupt. A 4-bit subcommand starts at bit 12, and an input byte count starts at bit 16. While a command is outstanding, the busy flag in the status word stays set. When the firmware finishes, busy drops and a pending flag rises. The host either polls the busy flag, or it sets bit 8 and waits for `host_irq`. It then acknowledges by writing a one to the pending bit.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the status word reads 0, the inbound and outbound data words read 0, and `fw_doorbell` and `host_irq` are low.
- R2: A host write to offset 0x00 while not busy stores the command and sets busy (status bit 0) from the next cycle. It also drives `fw_doorbell` high for exactly that one cycle. The firmware outputs then show the fields: opcode = bits 7:0, subcommand = bits 15:12, input length = bits 23:16.
- R3: A command write while busy is ignored. There is no doorbell pulse, and the stored command and the firmware fields keep their values.
- R4: `fw_done` while busy clears busy and sets the pending flag (status bit 2). It also latches `fw_err` into status bit 1, and latches `fw_err_code` into status bits 23:16, or 0 when `fw_err` is low.
- R5: `fw_done` while not busy changes nothing in the status word.
- R6: A host write to offset 0x04 with bit 2 set clears the pending flag, and a write with bit 2 clear leaves it alone. If `fw_done` completes a command in the same cycle, the flag stays set.
- R7: `host_irq` is high exactly when the pending flag is set and bit 8 of the last accepted command was 1.
- R8: The source pointer (0x08), the destination pointer (0x0C) and the four outbound words (0x80..0x8C) read back the last host value. The same values appear on `fw_src_ptr`, `fw_dst_ptr` and `fw_wbuf`, with word i in bits 32i+31:32i.
- R9: The inbound words (0x90..0x9C) read the values loaded through `fw_rbuf_we`/`fw_rbuf_idx`, and host writes to that range are ignored.
- R10: Accepting a new command clears the error flag and the error code, but not the pending flag.
- R11: A read of an unmapped offset returns 0. Every read returns its data with `h_rvalid` one cycle after `h_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | ADDR_W | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_we | input | 1 | Host write strobe |
| h_re | input | 1 | Host read strobe |
| h_rdata | output | 32 | Host read data |
| h_rvalid | output | 1 | Read data valid, one cycle after `h_re` |
| host_irq | output | 1 | Completion interrupt to host |
| fw_doorbell | output | 1 | One-cycle new-command pulse to firmware |
| fw_opcode | output | 8 | Opcode of stored command |
| fw_subcmd | output | 4 | Subcommand of stored command |
| fw_in_len | output | 8 | Input byte count of stored command |
| fw_src_ptr | output | 32 | Source pointer word |
| fw_dst_ptr | output | 32 | Destination pointer word |
| fw_wbuf | output | 32*BUF_WORDS | Outbound data words, flattened |
| fw_done | input | 1 | Completion strobe from firmware |
| fw_err | input | 1 | Error flag, sampled with `fw_done` |
| fw_err_code | input | 8 | Error code, sampled with `fw_done` |
| fw_rbuf_we | input | 1 | Inbound word load strobe |
| fw_rbuf_idx | input | $clog2(BUF_WORDS) | Inbound word index |
| fw_rbuf_data | input | 32 | Inbound word value |

## Verification
The bench sends a second command while the first is still busy. A design without the busy gate would ring the doorbell again and overwrite the opcode the firmware is working on. It raises `fw_done` when nothing is outstanding, to catch a design that latches a stray error code into an idle status word. In another cycle the bench drives the completion and the acknowledge together. A design that gives the clear priority would lose that completion, and the pending flag would read 0 instead of 1. The bench also issues one polled and one interrupt-mode command, to check that the interrupt tracks the stored request bit and not the pending flag alone. After that it checks that a new command wipes the old error code while the pending flag survives.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W = 32;
    localparam int CODE_W = 8;

    // command word fields
    localparam int OPC_LSB = 0;
    localparam int OPC_W   = 8;
    localparam int IRQ_REQ_BIT = 8;
    localparam int SUB_LSB = 12;
    localparam int SUB_W   = 4;
    localparam int LEN_LSB = 16;
    localparam int LEN_W   = 8;

    // status word fields
    localparam int ST_BUSY     = 0;
    localparam int ST_ERR      = 1;
    localparam int ST_PEND     = 2;
    localparam int ST_CODE_LSB = 16;

    // register offsets (bytes)
    localparam int OFS_CMD  = 'h00;
    localparam int OFS_STS  = 'h04;
    localparam int OFS_SRC  = 'h08;
    localparam int OFS_DST  = 'h0C;
    localparam int OFS_WBUF = 'h80;
    localparam int OFS_RBUF = 'h90;

    typedef enum logic [CODE_W-1:0] {
        MERR_NONE        = 8'd0,
        MERR_UNSUPPORTED = 8'd1,
        MERR_NOT_SERVED  = 8'd2,
        MERR_CANNOT_DO   = 8'd3,
        MERR_INVALID     = 8'd4,
        MERR_FAILED      = 8'd5,
        MERR_SECURITY    = 8'd6,
        MERR_UNSIGNED    = 8'd7
    } mbox_err_e;

    typedef struct packed {
        logic              busy;
        logic              pend;
        logic              err;
        logic [CODE_W-1:0] code;
        logic              irq_req;
        logic [DATA_W-1:0] cmd;
        logic              doorbell;
    } ctrl_state_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_state_t;

endpackage

// File: rtl/mbox_wordbank.sv
module mbox_wordbank #(
    parameter int WORDS = 4,
    parameter int DW    = 32,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [DW-1:0]     wdata,
    output logic [WORDS*DW-1:0] flat
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (we && (idx == IW'(g))) begin
                word_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign flat[g*DW +: DW] = word_q;
    end

    // R8 / R9: contents only change on a load strobe
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flat));

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              ack_we,
    input  logic              done,
    input  logic              err_in,
    input  logic [CODE_W-1:0] code_in,
    output logic              busy,
    output logic              pend,
    output logic              err,
    output logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] cmd,
    output logic              doorbell,
    output logic              host_irq
);

    ctrl_state_t st_d, st_q;
    logic accept, finish;

    always_comb begin
        st_d          = st_q;
        st_d.doorbell = 1'b0;
        accept        = cmd_we && !st_q.busy;
        finish        = done && st_q.busy;

        if (accept) begin
            st_d.busy     = 1'b1;
            st_d.cmd      = cmd_wdata;
            st_d.irq_req  = cmd_wdata[IRQ_REQ_BIT];
            st_d.doorbell = 1'b1;
            st_d.err      = 1'b0;
            st_d.code     = '0;
        end

        if (finish) begin
            st_d.busy = 1'b0;
            st_d.err  = err_in;
            st_d.code = err_in ? code_in : '0;
        end

        if (ack_we) begin
            st_d.pend = 1'b0;
        end
        if (finish) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign pend     = st_q.pend;
    assign err      = st_q.err;
    assign code     = st_q.code;
    assign cmd      = st_q.cmd;
    assign doorbell = st_q.doorbell;
    assign host_irq = st_q.pend && st_q.irq_req;

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy) |=> (busy && doorbell));

    p_ring_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);

    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we && !done) |=> (busy && !doorbell && $stable(cmd)));

    p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> (!busy && pend));

    p_code_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (code == '0));

    p_idle_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && done && !cmd_we) |=> (!busy && $stable(err) && $stable(code)));

    p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ack_we && !(busy && done)) |=> !pend);

    p_irq_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> cmd[IRQ_REQ_BIT]);

    p_new_cmd_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy) |=> (!err && (pend == $past(pend))));

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUF_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             h_addr,
    input  logic [31:0]                   h_wdata,
    input  logic                          h_we,
    input  logic                          h_re,
    output logic [31:0]                   h_rdata,
    output logic                          h_rvalid,
    output logic                          host_irq,
    output logic                          fw_doorbell,
    output logic [7:0]                    fw_opcode,
    output logic [3:0]                    fw_subcmd,
    output logic [7:0]                    fw_in_len,
    output logic [31:0]                   fw_src_ptr,
    output logic [31:0]                   fw_dst_ptr,
    output logic [32*BUF_WORDS-1:0]       fw_wbuf,
    input  logic                          fw_done,
    input  logic                          fw_err,
    input  logic [7:0]                    fw_err_code,
    input  logic                          fw_rbuf_we,
    input  logic [$clog2(BUF_WORDS)-1:0]  fw_rbuf_idx,
    input  logic [31:0]                   fw_rbuf_data
);

    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int BUF_BYTES = 4 * BUF_WORDS;

    localparam logic [ADDR_W-1:0] A_CMD      = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STS      = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_SRC      = ADDR_W'(OFS_SRC);
    localparam logic [ADDR_W-1:0] A_DST      = ADDR_W'(OFS_DST);
    localparam logic [ADDR_W-1:0] A_WBUF     = ADDR_W'(OFS_WBUF);
    localparam logic [ADDR_W-1:0] A_WBUF_END = ADDR_W'(OFS_WBUF + BUF_BYTES);
    localparam logic [ADDR_W-1:0] A_RBUF     = ADDR_W'(OFS_RBUF);
    localparam logic [ADDR_W-1:0] A_RBUF_END = ADDR_W'(OFS_RBUF + BUF_BYTES);

    // address decode
    logic hit_cmd, hit_sts, hit_ptr, hit_wbuf, hit_rbuf;
    logic [IDX_W-1:0] buf_idx;

    assign hit_cmd  = (h_addr == A_CMD);
    assign hit_sts  = (h_addr == A_STS);
    assign hit_ptr  = (h_addr == A_SRC) || (h_addr == A_DST);
    assign hit_wbuf = (h_addr >= A_WBUF) && (h_addr < A_WBUF_END);
    assign hit_rbuf = (h_addr >= A_RBUF) && (h_addr < A_RBUF_END);
    assign buf_idx  = h_addr[IDX_W+1:2];

    // control and status
    logic              busy, pend, err;
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] cmd;

    mbox_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (h_we && hit_cmd),
        .cmd_wdata (h_wdata),
        .ack_we    (h_we && hit_sts && h_wdata[ST_PEND]),
        .done      (fw_done),
        .err_in    (fw_err),
        .code_in   (fw_err_code),
        .busy      (busy),
        .pend      (pend),
        .err       (err),
        .code      (code),
        .cmd       (cmd),
        .doorbell  (fw_doorbell),
        .host_irq  (host_irq)
    );

    assign fw_opcode = cmd[OPC_LSB +: OPC_W];
    assign fw_subcmd = cmd[SUB_LSB +: SUB_W];
    assign fw_in_len = cmd[LEN_LSB +: LEN_W];

    // pointer words: index 0 = source, 1 = destination
    logic [63:0] ptr_flat;

    mbox_wordbank #(.WORDS(2), .DW(32)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (h_we && hit_ptr),
        .idx   (h_addr[2]),
        .wdata (h_wdata),
        .flat  (ptr_flat)
    );

    assign fw_src_ptr = ptr_flat[31:0];
    assign fw_dst_ptr = ptr_flat[63:32];

    // outbound (host-written) and inbound (firmware-written) data
    logic [32*BUF_WORDS-1:0] rbuf_flat;

    mbox_wordbank #(.WORDS(BUF_WORDS), .DW(32)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (h_we && hit_wbuf),
        .idx   (buf_idx),
        .wdata (h_wdata),
        .flat  (fw_wbuf)
    );

    mbox_wordbank #(.WORDS(BUF_WORDS), .DW(32)) u_rbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fw_rbuf_we),
        .idx   (fw_rbuf_idx),
        .wdata (fw_rbuf_data),
        .flat  (rbuf_flat)
    );

    // registered read port
    logic [31:0] status_word;
    rd_state_t   rd_d, rd_q;

    always_comb begin
        status_word                             = '0;
        status_word[ST_BUSY]                    = busy;
        status_word[ST_ERR]                     = err;
        status_word[ST_PEND]                    = pend;
        status_word[ST_CODE_LSB +: CODE_W]      = code;
    end

    always_comb begin
        rd_d.valid = h_re;
        rd_d.data  = '0;
        if (h_re) begin
            if (hit_cmd) begin
                rd_d.data = cmd;
            end else if (hit_sts) begin
                rd_d.data = status_word;
            end else if (hit_ptr) begin
                rd_d.data = h_addr[2] ? ptr_flat[63:32] : ptr_flat[31:0];
            end else if (hit_wbuf) begin
                rd_d.data = fw_wbuf[buf_idx*32 +: 32];
            end else if (hit_rbuf) begin
                rd_d.data = rbuf_flat[buf_idx*32 +: 32];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign h_rdata  = rd_q.data;
    assign h_rvalid = rd_q.valid;

    p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        h_re |=> h_rvalid);

    p_idle_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !h_rvalid |-> (h_rdata == '0));

endmodule

// File: tb/tb_cmd_mailbox.sv
module tb_cmd_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int BUF_WORDS  = 4;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic [ADDR_W-1:0]            h_addr = '0;
    logic [31:0]                  h_wdata = '0;
    logic                         h_we = 1'b0;
    logic                         h_re = 1'b0;
    logic [31:0]                  h_rdata;
    logic                         h_rvalid;
    logic                         host_irq;
    logic                         fw_doorbell;
    logic [7:0]                   fw_opcode;
    logic [3:0]                   fw_subcmd;
    logic [7:0]                   fw_in_len;
    logic [31:0]                  fw_src_ptr;
    logic [31:0]                  fw_dst_ptr;
    logic [32*BUF_WORDS-1:0]      fw_wbuf;
    logic                         fw_done = 1'b0;
    logic                         fw_err = 1'b0;
    logic [7:0]                   fw_err_code = '0;
    logic                         fw_rbuf_we = 1'b0;
    logic [1:0]                   fw_rbuf_idx = '0;
    logic [31:0]                  fw_rbuf_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_mailbox #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_addr       (h_addr),
        .h_wdata      (h_wdata),
        .h_we         (h_we),
        .h_re         (h_re),
        .h_rdata      (h_rdata),
        .h_rvalid     (h_rvalid),
        .host_irq     (host_irq),
        .fw_doorbell  (fw_doorbell),
        .fw_opcode    (fw_opcode),
        .fw_subcmd    (fw_subcmd),
        .fw_in_len    (fw_in_len),
        .fw_src_ptr   (fw_src_ptr),
        .fw_dst_ptr   (fw_dst_ptr),
        .fw_wbuf      (fw_wbuf),
        .fw_done      (fw_done),
        .fw_err       (fw_err),
        .fw_err_code  (fw_err_code),
        .fw_rbuf_we   (fw_rbuf_we),
        .fw_rbuf_idx  (fw_rbuf_idx),
        .fw_rbuf_data (fw_rbuf_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n && h_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected read data", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), h_rdata, exp_q.pop_front());
            end
        end
    end

    // all driver tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        h_addr = a; h_wdata = d; h_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        h_addr = a; h_re = 1'b1;
        @(negedge clk);
        h_re = 1'b0;
    endtask

    task automatic fw_finish(input logic e, input logic [7:0] c);
        fw_done = 1'b1; fw_err = e; fw_err_code = c;
        @(negedge clk);
        fw_done = 1'b0; fw_err = 1'b0; fw_err_code = '0;
    endtask

    task automatic fw_load(input logic [1:0] i, input logic [31:0] d);
        fw_rbuf_we = 1'b1; fw_rbuf_idx = i; fw_rbuf_data = d;
        @(negedge clk);
        fw_rbuf_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 doorbell", {31'b0, fw_doorbell}, 32'h0);
        chk("R1 irq", {31'b0, host_irq}, 32'h0);
        rd(8'h04, 32'h0, "R1 status");
        rd(8'h90, 32'h0, "R1 inbound word");
        rd(8'h80, 32'h0, "R1 outbound word");

        // R8 pointers and outbound words
        wr(8'h08, 32'h1234_5678);
        wr(8'h0C, 32'h9ABC_DEF0);
        for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4*i), 32'hA000_0000 + i);
        rd(8'h08, 32'h1234_5678, "R8 src ptr read");
        rd(8'h0C, 32'h9ABC_DEF0, "R8 dst ptr read");
        rd(8'h88, 32'hA000_0002, "R8 outbound word 2");
        chk("R8 fw src ptr", fw_src_ptr, 32'h1234_5678);
        chk("R8 fw dst ptr", fw_dst_ptr, 32'h9ABC_DEF0);
        chk("R8 fw outbound word 1", fw_wbuf[63:32], 32'hA000_0001);

        // R2 command with interrupt request: op 5, sub 2, len 3
        wr(8'h00, 32'h0003_2105);
        chk("R2 doorbell pulse", {31'b0, fw_doorbell}, 32'h1);
        chk("R2 opcode", {24'b0, fw_opcode}, 32'h05);
        chk("R2 subcmd", {28'b0, fw_subcmd}, 32'h2);
        chk("R2 length", {24'b0, fw_in_len}, 32'h3);
        @(negedge clk);
        chk("R2 doorbell one cycle", {31'b0, fw_doorbell}, 32'h0);
        rd(8'h04, 32'h0000_0001, "R2 busy status");

        // R3 second command while busy
        wr(8'h00, 32'h0000_0077);
        chk("R3 no doorbell", {31'b0, fw_doorbell}, 32'h0);
        chk("R3 opcode kept", {24'b0, fw_opcode}, 32'h05);
        rd(8'h00, 32'h0003_2105, "R3 command kept");

        // R9 inbound words
        fw_load(2'd0, 32'hC0DE_0000);
        fw_load(2'd3, 32'hC0DE_0003);
        wr(8'h90, 32'hFFFF_FFFF);
        rd(8'h90, 32'hC0DE_0000, "R9 inbound word 0");
        rd(8'h9C, 32'hC0DE_0003, "R9 inbound word 3");

        // R4/R7 completion without error, interrupt requested
        fw_finish(1'b0, 8'h00);
        chk("R7 irq with request", {31'b0, host_irq}, 32'h1);
        rd(8'h04, 32'h0000_0004, "R4 pending no error");

        // R5 stray done while idle
        fw_finish(1'b1, 8'h33);
        rd(8'h04, 32'h0000_0004, "R5 idle done ignored");

        // R6 acknowledge
        wr(8'h04, 32'h0000_0003);
        rd(8'h04, 32'h0000_0004, "R6 write without bit2");
        wr(8'h04, 32'h0000_0004);
        chk("R6 irq cleared", {31'b0, host_irq}, 32'h0);
        rd(8'h04, 32'h0000_0000, "R6 pending cleared");

        // R7/R4 polled command finishing with error code 5
        wr(8'h00, 32'h0000_0009);
        chk("R2 polled doorbell", {31'b0, fw_doorbell}, 32'h1);
        fw_finish(1'b1, 8'h05);
        chk("R7 no irq when polled", {31'b0, host_irq}, 32'h0);
        rd(8'h04, 32'h0005_0006, "R4 error status");

        // R10 new command clears error, keeps pending
        wr(8'h00, 32'h0000_0101);
        rd(8'h04, 32'h0000_0005, "R10 error cleared");
        chk("R7 irq follows new request", {31'b0, host_irq}, 32'h1);

        // R6 done and acknowledge in the same cycle
        fw_done = 1'b1; h_addr = 8'h04; h_wdata = 32'h4; h_we = 1'b1;
        @(negedge clk);
        fw_done = 1'b0; h_we = 1'b0;
        rd(8'h04, 32'h0000_0004, "R6 done beats ack");
        wr(8'h04, 32'h0000_0004);

        // R11 unmapped offset
        rd(8'h40, 32'h0, "R11 unmapped read");
        rd(8'h04, 32'h0, "R6 final status");

        @(negedge clk);
        @(negedge clk);
        chk("R11 all reads returned", exp_q.size(), 32'h0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule